// File: doc/BRIEF.md
# External Bus Switch with Wait States

The switch arbitrates one shared external memory bus among three internal buses: an instruction bus and two data buses, called X and Y. Each internal bus raises a strobe and holds it, along with its address, direction and write data, until the switch pulses that space's completion flag. When the strobe rises, the switch checks the top address bits against two programmable boundaries for that space. The result marks the access as on-chip, which the switch ignores, or off-chip, which the switch serves.

Off-chip accesses run one at a time. A cycle lasts two clocks plus a programmed number of two-clock wait states. An active-low acknowledge input from outside can stretch the cycle further. The switch drives the external address, data and per-space strobes in one of two styles. Intel style uses separate read and write strobes. Motorola style uses a data strobe plus a read/write line. A space can also be set to direct mode. In direct mode the switch only counts the wait states and acknowledges, and leaves the external strobes idle.

Top module: `ext_bus_switch`

## Requirements
- R1: A space's access is off-chip when address bits 15:10 are greater than or equal to the boundary field (bits 9:4) of either of that space's two control words. `bus_ext[s]` shows this decision from the current address.
- R2: Control word 1 is tested first. If its boundary matches, its wait count, style and enable bits govern the access. Otherwise word 0 governs it. Words are indexed by `cfg_addr` = 2*space + word, with space 0 = I, 1 = X, 2 = Y.
- R3: With wait field F (bits 3:0), the cycle has W = F+1 wait states and lasts 2*(W+1) clocks. `bus_done[s]` is seen 2*(W+1)+2 rising edges after the strobe rises, provided `dtack_n` is low.
- R4: While `dtack_n` is high, the cycle does not end. It ends at the first edge where both the programmed length has elapsed and `dtack_n` is low.
- R5: Off-chip requests that are pending together are served in the order I, X, Y. One idle clock separates consecutive cycles.
- R6: With bit 15 = 1 (Intel), the space's `ext_rd_n` is low during a read and `ext_wr_n` is low during a write.
- R7: With bit 15 = 0 (Motorola), `ext_rd_n` acts as a data strobe and is low for the whole cycle. `ext_wr_n` acts as the read/write line and is 0 for a write, 1 for a read.
- R8: With bit 14 = 0 (direct), all external strobes stay high and the data bus is not driven. The wait count and completion still apply.
- R9: After reset, every space's word 0 reads 0x83EF and word 1 reads 0x83FF.
- R10: Bits 13:10 always read 0, and writes to them are ignored. `cfg_addr` values 6 and 7 read 0 and accept no write.
- R11: An on-chip access produces no completion flag and no external strobe activity.
- R12: `core_dtack_n` is the OR of `dtack_n` and the switch's own acknowledge. It is low only in the final clock of an off-chip cycle.
- R13: An off-chip read in switch mode captures `ext_rdata` into `rd_data` at completion. A write drives `ext_wdata` and `ext_addr` with `ext_data_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write enable |
| cfg_addr | input | 3 | Control word index, 2*space + word |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data for `cfg_addr` |
| bus_stb | input | 3 | Per-space access strobe, held until done |
| bus_we | input | 3 | Per-space direction, 1 = write |
| bus_addr | input | 48 | Per-space 16-bit addresses, I in bits 15:0 |
| bus_wdata | input | 48 | Per-space 16-bit write data |
| bus_ext | output | 3 | Per-space off-chip decision |
| bus_done | output | 3 | One-clock completion pulse per space |
| rd_data | output | 16 | Data captured by the last external read |
| dtack_n | input | 1 | External acknowledge, active low |
| core_dtack_n | output | 1 | Combined acknowledge to the core, active low |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 16 | External write data |
| ext_data_oe | output | 1 | External data output enable |
| ext_rdata | input | 16 | External read data |
| ext_rd_n | output | 3 | Per-space read strobe or data strobe |
| ext_wr_n | output | 3 | Per-space write strobe or read/write line |

## Verification
The assertions assume that a space holds its strobe, address, direction and write data steady from the rising strobe until its completion pulse. They also assume that the strobe drops before the next request from that space. The bench follows this rule: it changes a request's fields only on a falling clock edge together with the strobe's rise, and it lowers the strobe in the cycle after the completion pulse appears. Random addresses cluster around the programmed boundaries. Random acknowledge delays fall both below and above the programmed length, so both stretched cycles and cycles set by the wait count occur.

// File: rtl/ext_bus_switch.sv
module ext_bus_switch #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BW  = 6,
  parameter int WSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic [2:0]      bus_stb,
  input  logic [2:0]      bus_we,
  input  logic [3*AW-1:0] bus_addr,
  input  logic [3*DW-1:0] bus_wdata,
  output logic [2:0]      bus_ext,
  output logic [2:0]      bus_done,
  output logic [DW-1:0]   rd_data,
  input  logic            dtack_n,
  output logic            core_dtack_n,
  output logic [AW-1:0]   ext_addr,
  output logic [DW-1:0]   ext_wdata,
  output logic            ext_data_oe,
  input  logic [DW-1:0]   ext_rdata,
  output logic [2:0]      ext_rd_n,
  output logic [2:0]      ext_wr_n
);
  localparam int NS   = 3;
  localparam int NR   = 2 * NS;
  localparam int TMAX = 2 * ((1 << WSW) + 1);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int BLO  = WSW;
  localparam int BHI  = WSW + BW - 1;
  localparam logic [15:0] MASK = 16'hC000 | 16'((1 << (BW + WSW)) - 1);
  localparam logic [15:0] RST0 = 16'h8000 | 16'(((1 << BW) - 2) << WSW) | 16'((1 << WSW) - 1);
  localparam logic [15:0] RST1 = 16'h8000 | 16'(((1 << BW) - 1) << WSW) | 16'((1 << WSW) - 1);

  logic [15:0] cfg [NR];
  logic [15:0] sel [NS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) cfg[i] <= (i % 2 == 1) ? RST1 : RST0;
    end else if (cfg_we) begin
      for (int i = 0; i < NR; i++)
        if (int'(cfg_addr) == i) cfg[i] <= cfg_wdata & MASK;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NR; i++)
      if (int'(cfg_addr) == i) cfg_rdata = cfg[i];
  end

  for (genvar s = 0; s < NS; s++) begin : g_dec
    logic [BW-1:0] tag;
    logic hit1, hit0;
    assign tag        = bus_addr[s*AW+AW-1 -: BW];
    assign hit1       = tag >= cfg[2*s+1][BHI:BLO];
    assign hit0       = tag >= cfg[2*s][BHI:BLO];
    assign bus_ext[s] = hit1 | hit0;
    assign sel[s]     = hit1 ? cfg[2*s+1] : cfg[2*s];
  end

  logic [2:0] stb_q, pend;
  logic       act, fin, own_ack_n;
  logic [1:0] sp;
  logic [CW-1:0] cnt, tlim;
  logic       c_style, c_en, c_we;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;

  logic       pick_v;
  logic [1:0] pick;
  logic [15:0] pick_cfg;
  logic [AW-1:0] pick_addr;
  logic [DW-1:0] pick_wdata;
  logic       pick_we;

  always_comb begin
    pick_v = 1'b0; pick = '0; pick_cfg = '0;
    pick_addr = '0; pick_wdata = '0; pick_we = 1'b0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (pend[s]) begin
        pick_v     = 1'b1;
        pick       = 2'(s);
        pick_cfg   = sel[s];
        pick_addr  = bus_addr[s*AW +: AW];
        pick_wdata = bus_wdata[s*DW +: DW];
        pick_we    = bus_we[s];
      end
    end
  end

  assign own_ack_n    = ~(act && cnt == tlim);
  assign core_dtack_n = dtack_n | own_ack_n;
  assign fin          = act & ~core_dtack_n;

  logic [2:0] clr;
  assign clr = (!act && pick_v) ? (3'b001 << pick) : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      pend  <= '0;
    end else begin
      stb_q <= bus_stb;
      pend  <= (pend | (bus_stb & ~stb_q & bus_ext)) & ~clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; sp <= '0; cnt <= '0; tlim <= '0;
      c_style <= 1'b1; c_en <= 1'b0; c_we <= 1'b0;
      c_addr <= '0; c_wdata <= '0;
      bus_done <= '0; rd_data <= '0;
    end else begin
      bus_done <= '0;
      if (!act) begin
        if (pick_v) begin
          act     <= 1'b1;
          sp      <= pick;
          cnt     <= '0;
          tlim    <= CW'((32'(pick_cfg[WSW-1:0]) + 2) * 2 - 1);
          c_style <= pick_cfg[15];
          c_en    <= pick_cfg[14];
          c_we    <= pick_we;
          c_addr  <= pick_addr;
          c_wdata <= pick_wdata;
        end
      end else if (fin) begin
        act      <= 1'b0;
        bus_done <= 3'b001 << sp;
        if (c_en && !c_we) rd_data <= ext_rdata;
      end else if (cnt != tlim) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_stb
    logic on;
    assign on          = act && c_en && (sp == 2'(s));
    assign ext_rd_n[s] = ~(on && (c_style ? ~c_we : 1'b1));
    assign ext_wr_n[s] = ~(on && c_we);
  end

  assign ext_addr    = act ? c_addr : '0;
  assign ext_wdata   = c_wdata;
  assign ext_data_oe = act & c_en & c_we;

  // R5
  pick_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && pend[0]) |=> (act && sp == 2'd0));
  // R11
  one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~ext_rd_n) <= 1) && ($countones(~ext_wr_n) <= 1));
  // R8
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> ((&ext_rd_n) && (&ext_wr_n) && !ext_data_oe));
  // R12
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done != 3'b000) |-> ($past(!core_dtack_n) && !act));
  // R3
  act_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |=> act ##1 act ##1 act);
  // R4
  dtack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && dtack_n) |=> (act && bus_done == 3'b000));
  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~MASK) == 16'h0000);
  // R5
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_done));
endmodule

// File: tb/ext_bus_switch_test.sv
`timescale 1ns/1ps
module ext_bus_switch_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic [2:0] bus_stb = 0, bus_we = 0;
  logic [47:0] bus_addr = 0, bus_wdata = 0;
  logic [2:0] bus_ext, bus_done;
  logic [15:0] rd_data;
  logic dtack_n = 0, core_dtack_n;
  logic [15:0] ext_addr, ext_wdata, ext_rdata = 0;
  logic ext_data_oe;
  logic [2:0] ext_rd_n, ext_wr_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] shadow [6];

  ext_bus_switch uut (.*);

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [15:0] pick_word(int s, logic [15:0] a, output bit ext);
    logic [5:0] t = a[15:10];
    ext = 1;
    if (t >= shadow[2*s+1][9:4]) return shadow[2*s+1];
    if (t >= shadow[2*s][9:4]) return shadow[2*s];
    ext = 0;
    return shadow[2*s];
  endfunction

  task automatic wr_cfg(int idx, logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (idx < 6) shadow[idx] = v & 16'hC3FF;
  endtask

  task automatic rd_cfg(int idx, logic [15:0] e, string req);
    @(negedge clk);
    cfg_addr = 3'(idx);
    #1;
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic access(int s, logic [15:0] a, bit we, logic [15:0] wd, logic [15:0] rv, int kd);
    bit ext;
    logic [15:0] w;
    int t, en_n, n;
    bit got;
    @(negedge clk);
    w = pick_word(s, a, ext);
    t = 2 * (int'(w[3:0]) + 2);
    en_n = (t + 2 > kd + 1) ? t + 2 : kd + 1;
    bus_addr[s*16 +: 16] = a; bus_wdata[s*16 +: 16] = wd;
    bus_we[s] = we; ext_rdata = rv; dtack_n = (kd > 0);
    bus_stb[s] = 1;
    #1;
    chk(bus_ext[s] == ext, "R1 R2 decision", bus_ext[s], ext);
    got = 0; n = 0;
    for (int i = 1; i <= (ext ? 80 : 40); i++) begin
      @(posedge clk); @(negedge clk);
      if (i == kd) dtack_n = 0;
      #1;
      if (ext && i == 3) begin
        logic [2:0] er = 3'b111, ew = 3'b111;
        if (w[14]) begin
          er[s] = w[15] ? we : 1'b0;
          ew[s] = ~we;
        end
        chk(ext_rd_n == er, w[14] ? (w[15] ? "R6 intel rd" : "R7 moto ds") : "R8 direct rd", ext_rd_n, er);
        chk(ext_wr_n == ew, w[14] ? "R6 R7 wr/rw" : "R8 direct wr", ext_wr_n, ew);
        chk(ext_data_oe == (w[14] & we), "R8 R13 oe", ext_data_oe, w[14] & we);
        if (w[14] && we) chk(ext_addr == a && ext_wdata == wd, "R13 write bus", ext_wdata, wd);
        chk(core_dtack_n == 1, "R12 ack high early", core_dtack_n, 1);
      end
      if (ext && i == en_n - 1) chk(core_dtack_n == 0, "R12 ack final", core_dtack_n, 0);
      if (!ext) chk(&ext_rd_n && &ext_wr_n, "R11 idle strobes", {ext_rd_n, ext_wr_n}, 6'h3f);
      if (bus_done[s]) begin got = 1; n = i; break; end
    end
    if (ext) begin
      chk(got && n == en_n, kd > t + 1 ? "R4 stretch" : "R3 length", n, en_n);
      if (w[14] && !we) chk(rd_data == rv, "R13 read data", rd_data, rv);
    end else chk(!got, "R11 no done", got, 0);
    bus_stb[s] = 0; dtack_n = 0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tI, tX, tY, nd [3];
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) shadow[i] = (i % 2) ? 16'h83FF : 16'h83EF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(bus_done == 0 && &ext_rd_n && &ext_wr_n && core_dtack_n, "R12 reset idle", bus_done, 0);
    for (int i = 0; i < 6; i++) rd_cfg(i, (i % 2) ? 16'h83FF : 16'h83EF, "R9 reset value");

    wr_cfg(3, 16'hFFFF);
    rd_cfg(3, 16'hC3FF, "R10 unused bits");
    wr_cfg(6, 16'h1234);
    rd_cfg(6, 16'h0000, "R10 index 6");
    rd_cfg(7, 16'h0000, "R10 index 7");
    for (int i = 0; i < 6; i++) rd_cfg(i, shadow[i], "R10 no alias");

    wr_cfg(0, 16'hC082); wr_cfg(1, 16'h40F0);
    access(0, 16'h2000, 0, 0, 16'hA5A5, 0);
    access(0, 16'h3C00, 1, 16'h5A5A, 0, 0);
    access(0, 16'h1C00, 0, 0, 0, 0);
    access(0, 16'h2000, 0, 0, 16'h1111, 20);
    wr_cfg(2, 16'h8010); wr_cfg(3, 16'h8FF0);
    access(1, 16'h0400, 1, 16'h0F0F, 0, 0);
    wr_cfg(4, 16'hC000); wr_cfg(5, 16'hC3F3);
    access(2, 16'h0000, 0, 0, 16'hBEEF, 0);
    access(2, 16'hFC00, 1, 16'hCAFE, 0, 0);

    wr_cfg(0, 16'hC001); wr_cfg(2, 16'hC003); wr_cfg(4, 16'hC005);
    wr_cfg(1, 16'hC3FF); wr_cfg(3, 16'hC3FF); wr_cfg(5, 16'hC3FF);
    tI = 2 * (1 + 2); tX = 2 * (3 + 2); tY = 2 * (5 + 2);
    @(negedge clk);
    bus_addr = 48'h0; bus_we = 3'b000; dtack_n = 0;
    bus_stb = 3'b111;
    nd = '{0, 0, 0};
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk); @(negedge clk); #1;
      for (int s = 0; s < 3; s++) if (bus_done[s]) begin nd[s] = i; bus_stb[s] = 0; end
      if (bus_stb == 0) break;
    end
    chk(nd[0] == tI + 2, "R5 I first", nd[0], tI + 2);
    chk(nd[1] == tI + 2 + tX + 1, "R5 X second", nd[1], tI + 3 + tX);
    chk(nd[2] == tI + 2 + tX + 1 + tY + 1, "R5 Y third", nd[2], tI + tX + tY + 4);
    repeat (2) @(negedge clk);

    for (int it = 0; it < 80; it++) begin
      int s = $urandom_range(0, 2);
      logic [15:0] a;
      if ($urandom_range(0, 3) == 0)
        wr_cfg($urandom_range(0, 5), 16'($urandom));
      a = {shadow[2*s + $urandom_range(0, 1)][9:4], 10'h0};
      a[15:10] = 6'(int'(a[15:10]) + $urandom_range(0, 2) - 1);
      a[9:0] = 10'($urandom);
      access(s, a, 1'($urandom), 16'($urandom), 16'($urandom), $urandom_range(0, 1) ? 0 : $urandom_range(1, 40));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule